// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the two-wire slave front end of an 8K x 8 nonvolatile byte memory. A fast system clock oversamples SCL and SDA, which arrive already synchronised. The block finds start and stop conditions and checks the device address word. It then runs one of the transactions: byte or page writes, reads at the current address, random reads (a dummy write followed by a read), or sequential reads. It answers the bus through a single active-high pull-down enable for the open-drain SDA pad.

On the memory side, a combinational read port returns the byte at the current address counter. Each received data byte goes to an external write sequencer as a one-cycle strobe with its address. A commit pulse asks the sequencer to start the internal write cycle. While the sequencer reports busy, the block refuses every device address word, so the host can poll with write-mode headers until an acknowledge returns.

Top module: `nvm_twi_target`

## Requirements
- R1: The device address word (MSB first) must have bits 7..4 = 1010, bit 3 equal to the strap input `addr_sel_i`, and bits 2..1 = 00. Bit 0 selects the direction (1 = read, 0 = write). When the word matches, the block pulls SDA low during the 9th SCL clock. With the strap low only 7-bit address 0x50 is answered; with it high only 0x54.
- R2: A word that does not match gets no acknowledge, and the block stays released until the next start condition.
- R3: SDA is sampled on the rising edge of SCL, and the block changes its SDA drive only after a falling edge of SCL. `sda_pull_o` is high only during an acknowledge bit or while a 0 read bit is sent.
- R4: After a write-mode header, the block takes two word-address bytes, high byte first, and acknowledges each one. Bits 15..13 of the address are ignored. Each data byte that follows is acknowledged and issued as a single `wr_stb_o` cycle, with its 13-bit address on `wr_addr_o` and its data on `wr_data_o`.
- R5: Within a write, the low 5 address bits step by one per data byte and wrap inside the 32-byte page. Bits 12..5 stay fixed.
- R6: A stop condition raises `commit_o` for one cycle, one clock after the stop, but only if at least one data byte has been strobed since the last start. A stop after a header alone, or after a dummy write, gives no commit.
- R7: While `busy_i` is high, no device address word of either direction is acknowledged. Once `busy_i` falls, the same header is acknowledged again.
- R8: After a read-mode match, the block sends the byte at the current address counter, MSB first. Each 0 acknowledge from the master moves the counter on by one and sends the next byte. The counter wraps from 0x1FFF to 0x0000.
- R9: A 1 (no acknowledge) from the master after a read byte makes the block release SDA and wait for the next start.
- R10: The address counter is 0 after reset. After a read it points one past the last byte sent. After a write it points to the next address in the same page. After a dummy write it holds the loaded address.
- R11: A start condition at any point, including in the middle of a byte, aborts the transfer, discards any uncommitted write, and restarts address matching. A start, then nine clocks with SDA released, then a start, leaves the block ready for a new header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA bus level |
| addr_sel_i | input | 1 | Strap giving address bit 3 of the device word |
| sda_pull_o | output | 1 | Active-high pull-down enable for the SDA pad |
| rd_addr_o | output | 13 | Current address counter, read port address |
| rd_data_i | input | 8 | Memory byte at `rd_addr_o`, same cycle |
| wr_stb_o | output | 1 | One-cycle strobe for one received data byte |
| wr_addr_o | output | 13 | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| commit_o | output | 1 | One-cycle request to start the internal write |
| busy_i | input | 1 | Internal write cycle in progress |

## Verification
The bench builds the block with its default 13-bit address and 32-byte page, because the two-byte address phase and the wrap points at 0x1FFF and at page boundaries only exist at that size. It sweeps every 7-bit write-mode header against the strap. It crosses the array end and a page end with expected bytes computed from an arithmetic memory pattern. A bench sequencer raises busy for a fixed time after each commit, which exercises polling, the software reset sequence while busy, and read-back of committed data.

// File: rtl/nvm_twi_pkg.sv
// Shared types for the two-wire memory target.
// Assumes: nothing beyond the 1800-2017 language.
package nvm_twi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } twi_state_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/nvm_twi_line_events.sv
// Turns oversampled SCL/SDA levels into single-cycle bus events.
// Assumes: inputs are already synchronised to clk; the idle bus level is high.
module nvm_twi_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    logic scl_q;
    logic sda_q;

    // Hold the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // A data edge while the clock stays high is a bus condition.
    always_comb begin
        start_o = scl_q & scl_i & sda_q & ~sda_i;
        stop_o  = scl_q & scl_i & ~sda_q & sda_i;
        rise_o  = ~scl_q & scl_i;
        fall_o  = scl_q & ~scl_i;
    end

endmodule

// File: rtl/nvm_twi_addr_ctr.sv
// Current address counter: load, whole-array step, or in-page step.
// Assumes: at most one of the step requests is active per cycle; load wins.
module nvm_twi_addr_ctr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_full_i,
    input  logic              step_page_i,
    output logic [ADDR_W-1:0] cur_o
);

    // Update the counter: cleared at reset, then loaded or stepped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o <= '0;
        end else if (load_i) begin
            cur_o <= load_val_i;
        end else if (step_full_i) begin
            cur_o <= cur_o + 1'b1;
        end else if (step_page_i) begin
            cur_o <= {cur_o[ADDR_W-1:PAGE_W], cur_o[PAGE_W-1:0] + 1'b1};
        end
    end

    // R5: an in-page step never changes the page bits
    a_r5_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step_page_i && !load_i) |=> cur_o[ADDR_W-1:PAGE_W] == $past(cur_o[ADDR_W-1:PAGE_W]));

    // R8: a whole-array step from the top address lands on zero
    a_r8_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_full_i && !load_i && cur_o == '1) |=> cur_o == '0);

endmodule

// File: rtl/nvm_twi_target.sv
// Two-wire slave front end for a byte-addressed nonvolatile memory.
// Matches the device word, takes a two-byte word address, strobes write
// bytes to a sequencer, commits on stop, and streams read bytes.
// Assumes: SCL/SDA synchronised and oversampled several times per phase;
// rd_data_i is valid in the same cycle as rd_addr_o.
module nvm_twi_target
    import nvm_twi_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              commit_o,
    input  logic              busy_i
);

    localparam int HI_W = ADDR_W - 8;

    logic            start;
    logic            stop;
    logic            rise;
    logic            fall;
    twi_state_t      state;
    logic [3:0]      cnt;
    logic [7:0]      shreg;
    logic [7:0]      rbyte;
    logic [HI_W-1:0] ahi;
    logic            rw;
    logic            mack;
    logic            pending;
    logic            byte_done;
    logic            dev_match;
    logic            ctr_load;
    logic            ctr_step_full;
    logic            ctr_step_page;
    logic [ADDR_W-1:0] ctr;

    nvm_twi_line_events i_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (start),
        .stop_o  (stop),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    // Decode the address word and the counter requests for this cycle.
    always_comb begin
        byte_done     = fall && (cnt == 4'd8) && !start && !stop;
        dev_match     = (shreg[7:4] == DEV_CODE) && (shreg[3] == addr_sel_i) && (shreg[2:1] == 2'b00);
        ctr_load      = byte_done && (state == ST_ALO);
        ctr_step_page = byte_done && (state == ST_WDAT);
        ctr_step_full = fall && !start && !stop && (state == ST_RDAT) && (cnt == 4'd7);
    end

    nvm_twi_addr_ctr #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) i_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (ctr_load),
        .load_val_i  ({ahi, shreg}),
        .step_full_i (ctr_step_full),
        .step_page_i (ctr_step_page),
        .cur_o       (ctr)
    );

    assign rd_addr_o = ctr;

    // Command sequencer: bus conditions first, then the per-state bit work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            rbyte      <= '0;
            ahi        <= '0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            pending    <= 1'b0;
            sda_pull_o <= 1'b0;
            wr_stb_o   <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
            commit_o   <= 1'b0;
        end else begin
            wr_stb_o <= 1'b0;
            commit_o <= 1'b0;
            if (start) begin
                state      <= ST_DEV;
                cnt        <= '0;
                pending    <= 1'b0;
                sda_pull_o <= 1'b0;
            end else if (stop) begin
                state      <= ST_IDLE;
                commit_o   <= pending;
                pending    <= 1'b0;
                sda_pull_o <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                        if (rise && cnt != 4'd8) begin
                            shreg <= {shreg[6:0], sda_i};
                            cnt   <= cnt + 4'd1;
                        end
                        if (byte_done) begin
                            cnt <= '0;
                            if (state == ST_DEV) begin
                                if (dev_match && !busy_i) begin
                                    state      <= ST_DEV_ACK;
                                    sda_pull_o <= 1'b1;
                                    rw         <= shreg[0];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_AHI) begin
                                ahi        <= shreg[HI_W-1:0];
                                state      <= ST_AHI_ACK;
                                sda_pull_o <= 1'b1;
                            end else if (state == ST_ALO) begin
                                state      <= ST_ALO_ACK;
                                sda_pull_o <= 1'b1;
                            end else begin
                                wr_stb_o   <= 1'b1;
                                wr_addr_o  <= ctr;
                                wr_data_o  <= shreg;
                                pending    <= 1'b1;
                                state      <= ST_WDAT_ACK;
                                sda_pull_o <= 1'b1;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (fall) begin
                            if (rw) begin
                                state      <= ST_RDAT;
                                cnt        <= '0;
                                rbyte      <= rd_data_i;
                                sda_pull_o <= ~rd_data_i[7];
                            end else begin
                                state      <= ST_AHI;
                                sda_pull_o <= 1'b0;
                            end
                        end
                    end
                    ST_AHI_ACK: begin
                        if (fall) begin
                            state      <= ST_ALO;
                            sda_pull_o <= 1'b0;
                        end
                    end
                    ST_ALO_ACK, ST_WDAT_ACK: begin
                        if (fall) begin
                            state      <= ST_WDAT;
                            sda_pull_o <= 1'b0;
                        end
                    end
                    ST_RDAT: begin
                        if (fall) begin
                            if (cnt == 4'd7) begin
                                state      <= ST_RACK;
                                sda_pull_o <= 1'b0;
                            end else begin
                                cnt        <= cnt + 4'd1;
                                rbyte      <= {rbyte[6:0], 1'b0};
                                sda_pull_o <= ~rbyte[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (rise) begin
                            mack <= ~sda_i;
                        end
                        if (fall) begin
                            if (mack) begin
                                state      <= ST_RDAT;
                                cnt        <= '0;
                                rbyte      <= rd_data_i;
                                sda_pull_o <= ~rd_data_i[7];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_pull_o <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R7: a complete header seen while busy leaves the bus released
    a_r7_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && byte_done && busy_i) |=> (!sda_pull_o && state == ST_IDLE));

    // R6: a commit request only follows a stop condition
    a_r6_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(stop));

    // R4: a byte strobe coincides with acknowledging that byte
    a_r4_strobe_acks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (state == ST_WDAT_ACK && sda_pull_o));

    // R11: any start condition restarts header matching with SDA released
    a_r11_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_DEV && cnt == 4'd0 && !sda_pull_o));

    // R9: standby never pulls SDA
    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull_o);

    // R3: the pull-down only changes on a falling SCL edge or a bus condition
    a_r3_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !start && !stop) |=> $stable(sda_pull_o));

endmodule

// File: tb/test_nvm_twi_target.sv
// Self-checking bench: bus master tasks, arithmetic memory pattern,
// and a write sequencer model that holds busy after each commit.
module test_nvm_twi_target;

    localparam int Q    = 8;
    localparam int BUSY = 1500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        addr_sel = 1'b0;
    logic        sda_pull;
    logic        sda_line;
    logic [12:0] rd_addr;
    logic [7:0]  rd_data;
    logic        wr_stb;
    logic [12:0] wr_addr;
    logic [7:0]  wr_data;
    logic        commit;
    logic        busy;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    int          busy_cnt;
    int          n_stb;
    int          n_com;
    logic [12:0] last_a;
    logic [7:0]  last_d;
    logic [12:0] stg_a [32];
    logic [7:0]  stg_d [32];
    int          stg_n;
    logic        ov_v [256];
    logic [12:0] ov_a [256];
    logic [7:0]  ov_d [256];

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;
    assign busy     = (busy_cnt != 0);

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ {3'b101, a[12:8]};
    endfunction

    assign rd_data = (ov_v[rd_addr[7:0]] && ov_a[rd_addr[7:0]] == rd_addr) ?
                     ov_d[rd_addr[7:0]] : pat(rd_addr);

    nvm_twi_target i_nvm_twi_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .addr_sel_i (addr_sel),
        .sda_pull_o (sda_pull),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_data),
        .wr_stb_o   (wr_stb),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .commit_o   (commit),
        .busy_i     (busy)
    );

    // Write sequencer model: stage strobed bytes, apply on commit, hold busy.
    always @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= 0;
            n_stb    <= 0;
            n_com    <= 0;
            stg_n    <= 0;
            last_a   <= '0;
            last_d   <= '0;
            for (int i = 0; i < 256; i++) ov_v[i] <= 1'b0;
        end else begin
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
            if (wr_stb) begin
                n_stb  <= n_stb + 1;
                last_a <= wr_addr;
                last_d <= wr_data;
                if (stg_n < 32) begin
                    stg_a[stg_n] <= wr_addr;
                    stg_d[stg_n] <= wr_data;
                    stg_n        <= stg_n + 1;
                end
            end
            if (commit) begin
                for (int i = 0; i < 32; i++) begin
                    if (i < stg_n) begin
                        ov_v[stg_a[i][7:0]] <= 1'b1;
                        ov_a[stg_a[i][7:0]] <= stg_a[i];
                        ov_d[stg_a[i][7:0]] <= stg_d[i];
                    end
                end
                stg_n    <= 0;
                busy_cnt <= BUSY;
                n_com    <= n_com + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart;
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bstop;
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic bbit(input logic b, output logic s);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(Q);
        s = sda_line;
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bbit(b[i], s);
        bbit(1'b1, s);
        ack = ~s;
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bbit(1'b1, s);
            d = {d[6:0], s};
        end
        bbit(~mack, s);
    endtask

    task automatic wait_free;
        int guard = 0;
        while (busy && guard < 5000) begin
            tick(1);
            guard++;
        end
    endtask

    // Dummy write to addr then a repeated start in read mode.
    task automatic rand_read_hdr(input logic [15:0] a, output logic ok);
        logic k0, k1, k2, k3;
        bstart;
        wbyte({7'h50, 1'b0}, k0);
        wbyte(a[15:8], k1);
        wbyte(a[7:0], k2);
        bstart;
        wbyte({7'h50, 1'b1}, k3);
        ok = k0 & k1 & k2 & k3;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic       ack, ok, s;
        logic [7:0] d;
        int         tries;
        int         stb0;
        int         com0;

        tick(5);
        chk("R3 reset pull released", 32'(sda_pull), 0);
        chk("R10 reset counter on read port", 32'(rd_addr), 0);
        rst_n = 1'b1;
        tick(5);

        // R10/R8: current reads from the reset counter
        bstart;
        wbyte({7'h50, 1'b1}, ack);
        chk("R1 read header ack", 32'(ack), 1);
        rbyte(1'b0, d);
        chk("R8 current read at 0", 32'(d), 32'(pat(13'h0000)));
        bstop;
        chk("R9 released after nack+stop", 32'(sda_pull), 0);
        bstart;
        wbyte({7'h50, 1'b1}, ack);
        rbyte(1'b0, d);
        chk("R10 counter advanced after read", 32'(d), 32'(pat(13'h0001)));
        bstop;

        // R1/R2: sweep every 7-bit write header with the strap low
        for (int a = 0; a < 128; a++) begin
            bstart;
            wbyte({7'(a), 1'b0}, ack);
            bstop;
            chk("R1 R2 header sweep", 32'(ack), 32'(a == 'h50));
        end
        chk("R6 no commit for header-only writes", 32'(n_com), 0);

        // R1: strap high moves the answered address
        addr_sel = 1'b1;
        bstart; wbyte({7'h54, 1'b0}, ack); bstop;
        chk("R1 strap high answers 0x54", 32'(ack), 1);
        bstart; wbyte({7'h50, 1'b0}, ack); bstop;
        chk("R2 strap high ignores 0x50", 32'(ack), 0);
        addr_sel = 1'b0;

        // R4/R8: ignored top bits and wrap across the array end
        rand_read_hdr(16'hFFFE, ok);
        chk("R4 address bytes acked", 32'(ok), 1);
        rbyte(1'b1, d);
        chk("R8 seq read 0x1FFE", 32'(d), 32'(pat(13'h1FFE)));
        rbyte(1'b1, d);
        chk("R8 seq read 0x1FFF", 32'(d), 32'(pat(13'h1FFF)));
        rbyte(1'b1, d);
        chk("R8 seq read wraps to 0", 32'(d), 32'(pat(13'h0000)));
        rbyte(1'b0, d);
        chk("R8 seq read 0x0001", 32'(d), 32'(pat(13'h0001)));
        bstop;
        bstart; wbyte({7'h50, 1'b1}, ack); rbyte(1'b0, d); bstop;
        chk("R10 counter one past last read", 32'(d), 32'(pat(13'h0002)));

        // R6: dummy write then stop gives no commit
        bstart; wbyte({7'h50, 1'b0}, ack); wbyte(8'h00, ack); wbyte(8'h10, ack); bstop;
        tick(2);
        chk("R6 no commit after dummy write", 32'(n_com), 0);

        // R4/R6: byte write
        bstart;
        wbyte({7'h50, 1'b0}, ack);
        wbyte(8'hE1, ack);
        wbyte(8'h23, ack);
        wbyte(8'hA5, ack);
        chk("R4 data byte acked", 32'(ack), 1);
        chk("R4 one strobe", 32'(n_stb), 1);
        chk("R4 strobe address", 32'(last_a), 32'h0123);
        chk("R4 strobe data", 32'(last_d), 32'hA5);
        bstop;
        tick(2);
        chk("R6 commit after stop", 32'(n_com), 1);

        // R7: refused while busy, also after the software reset sequence
        bstart; wbyte({7'h50, 1'b0}, ack); bstop;
        chk("R7 write header refused while busy", 32'(ack), 0);
        bstart; wbyte({7'h50, 1'b1}, ack); bstop;
        chk("R7 read header refused while busy", 32'(ack), 0);
        bstart;
        for (int i = 0; i < 9; i++) bbit(1'b1, s);
        bstart;
        wbyte({7'h50, 1'b0}, ack);
        bstop;
        chk("R11 software reset does not bypass busy", 32'(ack), 0);
        tries = 0;
        ack = 1'b0;
        while (!ack && tries < 20) begin
            bstart; wbyte({7'h50, 1'b0}, ack); bstop;
            tries++;
        end
        chk("R7 polling acked after busy", 32'(ack), 1);
        chk("R7 polling saw a refusal first", 32'(tries > 1), 1);
        rand_read_hdr(16'h0123, ok);
        rbyte(1'b0, d);
        bstop;
        chk("R4 committed byte read back", 32'(d), 32'hA5);

        // R5: page write wrapping at the page end
        bstart;
        wbyte({7'h50, 1'b0}, ack);
        wbyte(8'h00, ack);
        wbyte(8'h5E, ack);
        wbyte(8'h11, ack);
        chk("R5 first page byte address", 32'(last_a), 32'h005E);
        wbyte(8'h22, ack);
        chk("R5 second page byte address", 32'(last_a), 32'h005F);
        wbyte(8'h33, ack);
        chk("R5 page wrap address", 32'(last_a), 32'h0040);
        wbyte(8'h44, ack);
        chk("R5 after wrap address", 32'(last_a), 32'h0041);
        bstop;
        tick(2);
        chk("R6 page commit", 32'(n_com), 2);
        wait_free;
        bstart; wbyte({7'h50, 1'b1}, ack); rbyte(1'b0, d); bstop;
        chk("R10 counter stays in page after write", 32'(d), 32'(pat(13'h0042)));
        rand_read_hdr(16'h005E, ok);
        rbyte(1'b1, d);
        chk("R5 read back 0x5E", 32'(d), 32'h11);
        rbyte(1'b1, d);
        chk("R5 read back 0x5F", 32'(d), 32'h22);
        rbyte(1'b0, d);
        chk("R8 read crosses page", 32'(d), 32'(pat(13'h0060)));
        bstop;
        rand_read_hdr(16'h0040, ok);
        rbyte(1'b1, d);
        chk("R5 wrapped byte at 0x40", 32'(d), 32'h33);
        rbyte(1'b0, d);
        chk("R5 wrapped byte at 0x41", 32'(d), 32'h44);
        bstop;

        // R11: start in the middle of a header restarts matching
        bstart;
        bbit(1'b1, s); bbit(1'b0, s); bbit(1'b1, s); bbit(1'b0, s);
        bstart;
        wbyte({7'h50, 1'b0}, ack);
        bstop;
        chk("R11 header after mid-byte start", 32'(ack), 1);

        // R11: start mid-byte after a strobed byte discards the write
        com0 = n_com;
        stb0 = n_stb;
        bstart;
        wbyte({7'h50, 1'b0}, ack);
        wbyte(8'h00, ack);
        wbyte(8'h70, ack);
        wbyte(8'h99, ack);
        chk("R4 strobe before abort", 32'(n_stb - stb0), 1);
        bbit(1'b0, s); bbit(1'b1, s); bbit(1'b0, s);
        bstart;
        wbyte({7'h50, 1'b1}, ack);
        chk("R11 read header after abort", 32'(ack), 1);
        rbyte(1'b0, d);
        chk("R10 counter after aborted write", 32'(d), 32'(pat(13'h0071)));
        bstop;
        tick(2);
        chk("R11 aborted write not committed", 32'(n_com - com0), 0);
        chk("R9 released in standby", 32'(sda_pull), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule